// File: doc/BRIEF.md
# Double-Buffered Video Memory Decoder

This block is the address decoder for a small 8-bit CPU system. The CPU has a 16-bit address bus. A 32 KB SRAM with a 15-bit address is shared between the CPU and a video scanout engine. From the CPU address, the read/write line and the clock phase, the block produces active-low selects for general RAM, ROM, a parallel I/O adapter (VIA), a serial adapter (ACIA) and an optional 4 KB dual-port RAM. It also produces an optional write strobe for a character-display RAM and the SRAM output and write enables.

The upper half of the SRAM holds two 8 KB video buffers. With double buffering on, the CPU window at $2000-$3FFF always reaches the buffer that is not being shown, and the scanout side always reads the shown buffer. Software flips the buffers by changing one control pin, and no copying is needed. Both control pins are captured only on a frame-boundary strobe, so a swap never happens part-way through a frame.

The block does not cover bus arbitration between the CPU and video sides. It gives one SRAM physical address for each side, and an external multiplexer chooses between them.

Top module: `vmd_top`

## Requirements
- R1: Addresses $8000-$FFFF drive `rom_cs_n` low. `rom_oe_n` is low only for a read (`cpu_rw`=1) in that range.
- R2: Addresses $0000-$3FFF drive `ram_cs_n` low. `sram_oe_n` is low only for a RAM read. `sram_we_n` is low only when RAM is selected, `cpu_rw`=0 and `phi2`=1, so a write to any I/O or ROM address never writes the SRAM.
- R3: `acia_cs_n` is low for $4000-$5FFF and `via_cs_n` is low for $6000-$6FFF. Exactly one of RAM, ROM, ACIA, VIA and dual-port selects is low for every address.
- R4: With double buffering on and display-select value s, a CPU access to $2000-$3FFF maps to SRAM address $4000 + (1-s)*$2000 + (address mod $2000).
- R5: The video side maps to SRAM address $4000 + s*$2000 + `vid_addr` when double buffering is on, and to $4000 + `vid_addr` when it is off. With double buffering off, CPU $2000-$3FFF maps straight to SRAM $2000-$3FFF. Every other CPU address maps to (address mod $8000).
- R6: `dbuf_en_pin` and `disp_sel_pin` take effect only on a rising clock edge where `frame_stb` is 1. Changes to them at any other time have no effect on either SRAM address.
- R7: A CPU write (`cpu_rw`=0) to $8000-$FFFF with `phi2`=1 drives `char_we_n` low. Reads in that range leave `char_we_n` high and enable ROM output instead.
- R8: Addresses $7000-$7FFF drive `dp_cs_n` low and keep `via_cs_n` high.
- R9: Synchronous active-low reset clears the captured state to double buffering off and display select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | CPU clock phase, high in second half of cycle |
| vid_addr | input | 13 | Scanout offset within an 8 KB buffer |
| frame_stb | input | 1 | Frame-boundary strobe that loads the control pins |
| dbuf_en_pin | input | 1 | 1 enables double buffering |
| disp_sel_pin | input | 1 | Buffer to display (0 or 1) |
| ram_cs_n | output | 1 | SRAM chip select for CPU |
| sram_oe_n | output | 1 | SRAM output enable for CPU reads |
| sram_we_n | output | 1 | SRAM write enable |
| sram_cpu_addr | output | 15 | SRAM physical address, CPU side |
| sram_vid_addr | output | 15 | SRAM physical address, video side |
| rom_cs_n | output | 1 | ROM chip select |
| rom_oe_n | output | 1 | ROM output enable |
| acia_cs_n | output | 1 | Serial adapter select |
| via_cs_n | output | 1 | Parallel I/O adapter select |
| dp_cs_n | output | 1 | Dual-port RAM select |
| char_we_n | output | 1 | Character-display RAM write strobe |

## Verification
On every cycle, the assertions check the following:
- exactly one device select is active;
- the SRAM write strobe only occurs for a RAM write in `phi2` high;
- the ROM output enable never occurs on a write and the character strobe never occurs on a read;
- the two sides always sit in opposite banks whenever the CPU is in the window with double buffering on;
- the captured control holds unless strobed.

The exact address boundaries of each select and the physical address arithmetic for each of the four control settings can only be shown by the bench's address sweeps. The same applies to the ignored pin changes between strobes and the reset state.

// File: rtl/vmd_pkg.sv
// Shared types for the double-buffered video memory decoder.
package vmd_pkg;

    // Control state captured at a frame boundary.
    typedef struct packed {
        logic dbuf_en;   // double buffering active
        logic disp_sel;  // buffer currently shown by scanout
    } buf_ctl_t;

    // Active-high decode hits for one CPU address.
    typedef struct packed {
        logic ram;   // general RAM region
        logic win;   // off-screen window region inside RAM
        logic rom;   // ROM region
        logic acia;  // serial adapter
        logic via;   // parallel I/O adapter
        logic dp;    // dual-port RAM
        logic chr;   // character RAM blind write
    } dec_hit_t;

endpackage

// File: rtl/vmd_ctl_latch.sv
// Frame-synchronous capture of the double-buffer control pins.
// Assumes frame_stb is a single-cycle pulse in the clk domain and the
// pins are already synchronous. Reset leaves buffering off, buffer 0.
module vmd_ctl_latch
    import vmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_stb,
    input  logic     dbuf_en_pin,
    input  logic     disp_sel_pin,
    output buf_ctl_t ctl
);

    // Load both pins together on the frame strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (frame_stb) begin
            ctl.dbuf_en  <= dbuf_en_pin;
            ctl.disp_sel <= disp_sel_pin;
        end
    end

    // R6: no strobe, no change
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(ctl));

    // R6: strobe loads the pins seen at that edge
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (ctl.dbuf_en == $past(dbuf_en_pin)) &&
                      (ctl.disp_sel == $past(disp_sel_pin)));

    // R9: reset clears the captured state
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (ctl == '0));

endmodule

// File: rtl/vmd_cpu_decode.sv
// CPU region decode from the top address nibble.
// Assumes a map split in sixteenths: RAM in the lowest quarter (window in
// its upper half), I/O in the second quarter, ROM in the upper half.
// Optional variants are picked by parameters through generate.
module vmd_cpu_decode
    import vmd_pkg::*;
#(
    parameter bit CHAR_WIN_EN = 1'b1,
    parameter bit DPRAM_EN    = 1'b1
) (
    input  logic [3:0] nib,
    input  logic       cpu_rw,
    output dec_hit_t   hit
);

    logic io_hit;
    logic dp_hit;
    logic chr_hit;

    // I/O occupies the quarter directly below ROM.
    assign io_hit = (nib[3:2] == 2'b01);

    // Dual-port RAM claims the top sixteenth of I/O when fitted.
    if (DPRAM_EN) begin : g_dp
        assign dp_hit = io_hit & nib[1] & nib[0];
    end else begin : g_no_dp
        assign dp_hit = 1'b0;
    end

    // Writes into ROM space become character RAM writes when fitted.
    if (CHAR_WIN_EN) begin : g_chr
        assign chr_hit = nib[3] & ~cpu_rw;
    end else begin : g_no_chr
        assign chr_hit = 1'b0;
    end

    // Assemble the region hits.
    always_comb begin
        hit.ram  = (nib[3:2] == 2'b00);
        hit.win  = (nib[3:1] == 3'b001);
        hit.rom  = nib[3];
        hit.acia = io_hit & ~nib[1];
        hit.dp   = dp_hit;
        hit.via  = io_hit & nib[1] & ~dp_hit;
        hit.chr  = chr_hit;
    end

endmodule

// File: rtl/vmd_sram_map.sv
// Physical SRAM address generation for the CPU and scanout sides.
// Assumes buffers at the two upper quarters of the SRAM; the CPU window
// reaches the hidden buffer, scanout the shown one.
module vmd_sram_map
    import vmd_pkg::*;
#(
    parameter int SRAM_AW = 15,
    localparam int BUF_AW = SRAM_AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRAM_AW-1:0] cpu_low,
    input  logic               win,
    input  logic [BUF_AW-1:0]  vid_addr,
    input  buf_ctl_t           ctl,
    output logic [SRAM_AW-1:0] cpu_phys,
    output logic [SRAM_AW-1:0] vid_phys
);

    // CPU side: redirect the window to the hidden buffer when enabled.
    always_comb begin
        if (win && ctl.dbuf_en) begin
            cpu_phys = {1'b1, ~ctl.disp_sel, cpu_low[BUF_AW-1:0]};
        end else begin
            cpu_phys = cpu_low;
        end
    end

    // Video side: shown buffer, buffer 0 when double buffering is off.
    always_comb begin
        vid_phys = {1'b1, ctl.dbuf_en & ctl.disp_sel, vid_addr};
    end

    // R4: CPU window and scanout never share a bank when enabled
    p_bank_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win && ctl.dbuf_en) |-> (cpu_phys[BUF_AW] != vid_phys[BUF_AW]));

    // R5: scanout never leaves the upper half of the SRAM
    p_vid_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vid_phys[SRAM_AW-1]);

endmodule

// File: rtl/vmd_top.sv
// Double-buffered video memory decoder, top level.
// Decodes CPU selects and strobes, maps both SRAM sides and captures the
// buffer control at frame boundaries. Strobes are active-low; the SRAM
// write strobe is gated by phi2 high.
module vmd_top
    import vmd_pkg::*;
#(
    parameter int CPU_AW      = 16,
    parameter bit CHAR_WIN_EN = 1'b1,
    parameter bit DPRAM_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              phi2,
    input  logic [CPU_AW-4:0] vid_addr,
    input  logic              frame_stb,
    input  logic              dbuf_en_pin,
    input  logic              disp_sel_pin,
    output logic              ram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [CPU_AW-2:0] sram_cpu_addr,
    output logic [CPU_AW-2:0] sram_vid_addr,
    output logic              rom_cs_n,
    output logic              rom_oe_n,
    output logic              acia_cs_n,
    output logic              via_cs_n,
    output logic              dp_cs_n,
    output logic              char_we_n
);

    localparam int SRAM_AW = CPU_AW - 1;

    buf_ctl_t ctl;
    dec_hit_t hit;

    vmd_ctl_latch u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .dbuf_en_pin (dbuf_en_pin),
        .disp_sel_pin(disp_sel_pin),
        .ctl         (ctl)
    );

    vmd_cpu_decode #(
        .CHAR_WIN_EN(CHAR_WIN_EN),
        .DPRAM_EN   (DPRAM_EN)
    ) u_dec (
        .nib   (cpu_addr[CPU_AW-1 -: 4]),
        .cpu_rw(cpu_rw),
        .hit   (hit)
    );

    vmd_sram_map #(
        .SRAM_AW(SRAM_AW)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_low (cpu_addr[SRAM_AW-1:0]),
        .win     (hit.win),
        .vid_addr(vid_addr),
        .ctl     (ctl),
        .cpu_phys(sram_cpu_addr),
        .vid_phys(sram_vid_addr)
    );

    // Turn decode hits into qualified active-low strobes.
    always_comb begin
        ram_cs_n  = ~hit.ram;
        sram_oe_n = ~(hit.ram & cpu_rw);
        sram_we_n = ~(hit.ram & ~cpu_rw & phi2);
        rom_cs_n  = ~hit.rom;
        rom_oe_n  = ~(hit.rom & cpu_rw);
        acia_cs_n = ~hit.acia;
        via_cs_n  = ~hit.via;
        dp_cs_n   = ~hit.dp;
        char_we_n = ~(hit.chr & phi2);
    end

    // R2: SRAM write only for a RAM write in phi2 high
    p_we_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!ram_cs_n && !cpu_rw && phi2));

    // R1: ROM drives the bus only on reads
    p_rom_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (cpu_rw && !rom_cs_n));

    // R3: exactly one device selected
    p_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ram_cs_n, ~rom_cs_n, ~acia_cs_n, ~via_cs_n, ~dp_cs_n}) == 1);

    // R7: character strobe only on writes, never with ROM output
    p_char_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !char_we_n |-> (!cpu_rw && rom_oe_n && !rom_cs_n));

    // R8: dual-port select excludes the VIA
    p_dp_via_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_cs_n |-> via_cs_n);

endmodule

// File: tb/tb_vmd_top.sv
// Sweep bench for vmd_top: address sweeps under all four control settings.
module tb_vmd_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        phi2 = 1'b0;
    logic [12:0] vid_addr = '0;
    logic        frame_stb = 1'b0;
    logic        dbuf_en_pin = 1'b0;
    logic        disp_sel_pin = 1'b0;
    logic        ram_cs_n, sram_oe_n, sram_we_n, rom_cs_n, rom_oe_n;
    logic        acia_cs_n, via_cs_n, dp_cs_n, char_we_n;
    logic [14:0] sram_cpu_addr, sram_vid_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vmd_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .phi2(phi2), .vid_addr(vid_addr), .frame_stb(frame_stb),
        .dbuf_en_pin(dbuf_en_pin), .disp_sel_pin(disp_sel_pin),
        .ram_cs_n(ram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_cpu_addr(sram_cpu_addr), .sram_vid_addr(sram_vid_addr),
        .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .acia_cs_n(acia_cs_n),
        .via_cs_n(via_cs_n), .dp_cs_n(dp_cs_n), .char_we_n(char_we_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, cpu_addr, act, exp);
        end
    endtask

    // Load control pins through a frame strobe.
    task automatic load_ctl(input bit en, input bit sel);
        @(negedge clk);
        dbuf_en_pin = en; disp_sel_pin = sel; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    // CPU sweep with expected values from the address arithmetic.
    task automatic cpu_sweep(input bit en, input bit sel);
        for (int i = 0; i < 4096; i++) begin
            int a;
            a = i * 16 + (i % 16);
            for (int m = 0; m < 4; m++) begin
                bit rw, p2, ram, rom, acia, via, dp, win;
                int phys;
                rw = m[0]; p2 = m[1];
                cpu_addr = a[15:0]; cpu_rw = rw; phi2 = p2;
                #1;
                ram  = a < 'h4000;
                rom  = a >= 'h8000;
                win  = a >= 'h2000 && a < 'h4000;
                acia = a >= 'h4000 && a < 'h6000;
                via  = a >= 'h6000 && a < 'h7000;
                dp   = a >= 'h7000 && a < 'h8000;
                chk("R2 ram_cs", ram_cs_n, !ram);
                chk("R2 sram_oe", sram_oe_n, !(ram && rw));
                chk("R2 sram_we", sram_we_n, !(ram && !rw && p2));
                chk("R1 rom_cs", rom_cs_n, !rom);
                chk("R1 rom_oe", rom_oe_n, !(rom && rw));
                chk("R3 acia_cs", acia_cs_n, !acia);
                chk("R3 via_cs", via_cs_n, !via);
                chk("R8 dp_cs", dp_cs_n, !dp);
                chk("R7 char_we", char_we_n, !(rom && !rw && p2));
                if (win && en) begin
                    phys = 'h4000 + (sel ? 0 : 'h2000) + (a % 'h2000);
                    chk("R4 cpu_phys", sram_cpu_addr, phys);
                end else begin
                    phys = a % 'h8000;
                    chk("R5 cpu_phys", sram_cpu_addr, phys);
                end
            end
        end
    endtask

    // Video sweep over every buffer offset.
    task automatic vid_sweep(input bit en, input bit sel);
        for (int v = 0; v < 8192; v++) begin
            vid_addr = v[12:0];
            #1;
            chk("R5 vid_phys", sram_vid_addr, 'h4000 + ((en && sel) ? 'h2000 : 0) + v);
        end
    endtask

    initial begin
        // R9: hold reset with pins requesting buffer 1, no strobe.
        dbuf_en_pin = 1'b1; disp_sel_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        vid_addr = 13'h0123; cpu_addr = 16'h2345;
        #1;
        chk("R9 reset vid_phys", sram_vid_addr, 'h4123);
        chk("R9 reset cpu_phys", sram_cpu_addr, 'h2345);

        for (int c = 0; c < 4; c++) begin
            load_ctl(c[1], c[0]);
            cpu_sweep(c[1], c[0]);
            vid_sweep(c[1], c[0]);
        end

        // R6: pin changes without a strobe are ignored.
        load_ctl(1'b1, 1'b0);
        @(negedge clk);
        dbuf_en_pin = 1'b1; disp_sel_pin = 1'b1;
        repeat (4) @(negedge clk);
        vid_addr = 13'h0042; cpu_addr = 16'h2042; cpu_rw = 1'b1;
        #1;
        chk("R6 vid_phys held", sram_vid_addr, 'h4042);
        chk("R6 cpu_phys held", sram_cpu_addr, 'h6042);
        dbuf_en_pin = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R6 enable held", sram_cpu_addr, 'h6042);
        // R6: strobe now applies the pins (en=0, sel=1).
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        #1;
        chk("R6 strobe vid_phys", sram_vid_addr, 'h4042);
        chk("R6 strobe cpu_phys", sram_cpu_addr, 'h2042);
        load_ctl(1'b1, 1'b1);
        #1;
        chk("R6 swap vid_phys", sram_vid_addr, 'h6042);
        chk("R6 swap cpu_phys", sram_cpu_addr, 'h4042);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule